// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two predictors side by side. The first is a table of 2-bit saturating counters addressed only by a 12-bit register that holds the most recent branch outcomes across the whole program. The second is a two-level scheme: the low bits of the branch address select a per-branch record of that branch's own last outcomes, and that record in turn selects a 3-bit saturating counter. A third table of small state machines, addressed by the same program-wide outcome register, picks which of the two answers is passed on.

Lookup is combinational: the fetch logic presents a branch address and gets a taken/not-taken answer in the same cycle, together with both component answers and the table indices that produced them. The pipeline carries those values with the branch. When the branch resolves, it returns them with the actual outcome on the update port, and on that clock edge every table is trained and the outcome is shifted into the program-wide record.

Top module: `tourney_bp`

## Requirements
- R1: After reset the outcome register and every per-branch record read 0, every counter predicts not taken (2-bit value 1, 3-bit value 3), and the output equals the global answer.
- R2: Each accepted update shifts the outcome register left by one and puts the outcome (1 taken, 0 not taken) in bit 0; `lk_gidx` shows the new value from the cycle after the update.
- R3: The global answer is bit 1 of a 2-bit counter addressed only by the outcome register; a taken update adds 1 and a not-taken update subtracts 1, saturating at 0 and 3.
- R4: The per-branch record is selected by branch address bits [9:0]; each update to that record shifts it left with the outcome in bit 0, keeping 10 bits, so addresses equal in bits [9:0] share one record.
- R5: The local answer is bit 2 of a 3-bit counter addressed by the per-branch record; taken adds 1, not taken subtracts 1, saturating at 0 and 7.
- R6: Each chooser holds a state 0..3; states 0 and 1 follow the global answer, 2 and 3 follow the local answer; reset state is 1.
- R7: When both component answers returned on update were right, or both were wrong, the addressed chooser keeps its state.
- R8: When only the global answer was right the chooser steps down by one (floor 0); when only the local answer was right it steps up by one (ceiling 3).
- R9: The output equals the component answer picked by the chooser addressed by the current outcome register.
- R10: With the update strobe low, values on the other update inputs change no table and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Branch address for lookup |
| lk_taken | output | 1 | Final prediction, 1 = taken |
| lk_gpred | output | 1 | Global component answer |
| lk_lpred | output | 1 | Local component answer |
| lk_gidx | output | 12 | Outcome register value used for lookup |
| lk_lidx | output | 10 | Per-branch record index used for lookup |
| lk_lhist | output | 10 | Per-branch record content used for lookup |
| up_valid | input | 1 | Update strobe |
| up_taken | input | 1 | Resolved outcome, 1 = taken |
| up_gidx | input | 12 | Outcome register value captured at lookup |
| up_lidx | input | 10 | Record index captured at lookup |
| up_lhist | input | 10 | Record content captured at lookup |
| up_gpred | input | 1 | Global answer captured at lookup |
| up_lpred | input | 1 | Local answer captured at lookup |

## Verification
The awkward case is reading a chosen entry of the global counter table or the chooser table, because both are addressed only by the outcome register, and every training update itself shifts that register. The stimulus trains the wanted entry through the update port's own index, then feeds twelve further updates aimed at a spare entry whose outcomes spell out the wanted index, so the register lands exactly on it before the lookup is sampled. The local counter table is reached the same way by writing ten outcomes into one per-branch record.

// File: rtl/tourney_bp.sv
module tourney_bp #(
  parameter int PC_W = 32,
  parameter int GH_W = 12,
  parameter int LI_W = 10,
  parameter int LH_W = 10,
  parameter int GC_W = 2,
  parameter int LC_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  output logic            lk_gpred,
  output logic            lk_lpred,
  output logic [GH_W-1:0] lk_gidx,
  output logic [LI_W-1:0] lk_lidx,
  output logic [LH_W-1:0] lk_lhist,
  input  logic            up_valid,
  input  logic            up_taken,
  input  logic [GH_W-1:0] up_gidx,
  input  logic [LI_W-1:0] up_lidx,
  input  logic [LH_W-1:0] up_lhist,
  input  logic            up_gpred,
  input  logic            up_lpred
);
  localparam int NG = 1 << GH_W;
  localparam int NL = 1 << LI_W;
  localparam int NP = 1 << LH_W;
  localparam logic [GC_W-1:0] GC_MAX  = '1;
  localparam logic [LC_W-1:0] LC_MAX  = '1;
  localparam logic [GC_W-1:0] GC_INIT = {1'b0, {(GC_W-1){1'b1}}};
  localparam logic [LC_W-1:0] LC_INIT = {1'b0, {(LC_W-1){1'b1}}};
  localparam logic [1:0]      CH_INIT = 2'd1;

  logic [GH_W-1:0] ghr;
  logic [GC_W-1:0] gctr       [NG];
  logic [1:0]      choose_tbl [NG];
  logic [LH_W-1:0] lhist_tbl  [NL];
  logic [LC_W-1:0] lctr       [NP];

  logic unused_pc_hi;
  assign unused_pc_hi = ^lk_pc[PC_W-1:LI_W];

  assign lk_gidx  = ghr;
  assign lk_lidx  = lk_pc[LI_W-1:0];
  assign lk_lhist = lhist_tbl[lk_lidx];
  assign lk_gpred = gctr[ghr][GC_W-1];
  assign lk_lpred = lctr[lk_lhist][LC_W-1];
  assign lk_taken = choose_tbl[ghr][1] ? lk_lpred : lk_gpred;

  logic [GC_W-1:0] gc_cur, gc_nxt;
  logic [LC_W-1:0] lc_cur, lc_nxt;
  logic [LH_W-1:0] lh_cur, lh_nxt;
  logic [1:0]      ch_cur, ch_nxt;
  logic            g_ok, l_ok;

  assign gc_cur = gctr[up_gidx];
  assign lc_cur = lctr[up_lhist];
  assign lh_cur = lhist_tbl[up_lidx];
  assign ch_cur = choose_tbl[up_gidx];
  assign g_ok   = (up_gpred == up_taken);
  assign l_ok   = (up_lpred == up_taken);

  always_comb begin
    gc_nxt = gc_cur;
    if (up_taken && gc_cur != GC_MAX) gc_nxt = gc_cur + 1'b1;
    else if (!up_taken && gc_cur != '0) gc_nxt = gc_cur - 1'b1;
  end

  always_comb begin
    lc_nxt = lc_cur;
    if (up_taken && lc_cur != LC_MAX) lc_nxt = lc_cur + 1'b1;
    else if (!up_taken && lc_cur != '0) lc_nxt = lc_cur - 1'b1;
  end

  always_comb begin
    ch_nxt = ch_cur;
    if (l_ok && !g_ok && ch_cur != 2'd3) ch_nxt = ch_cur + 2'd1;
    else if (g_ok && !l_ok && ch_cur != 2'd0) ch_nxt = ch_cur - 2'd1;
  end

  assign lh_nxt = {lh_cur[LH_W-2:0], up_taken};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ghr <= '0;
    else if (up_valid) ghr <= {ghr[GH_W-2:0], up_taken};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NG; i++) gctr[i] <= GC_INIT;
    end else if (up_valid) begin
      gctr[up_gidx] <= gc_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NG; i++) choose_tbl[i] <= CH_INIT;
    end else if (up_valid) begin
      choose_tbl[up_gidx] <= ch_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) lhist_tbl[i] <= '0;
    end else if (up_valid) begin
      lhist_tbl[up_lidx] <= lh_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NP; i++) lctr[i] <= LC_INIT;
    end else if (up_valid) begin
      lctr[up_lhist] <= lc_nxt;
    end
  end
endmodule

// File: rtl/tourney_bp_chk.sv
module tourney_bp_chk #(
  parameter int GH_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_taken,
  input logic            lk_gpred,
  input logic            lk_lpred,
  input logic [GH_W-1:0] lk_gidx,
  input logic            up_valid,
  input logic            up_taken,
  input logic [GH_W-1:0] up_gidx,
  input logic            up_gpred,
  input logic            up_lpred,
  input logic [1:0]      choose_tbl [1 << GH_W]
);
  a_r2_history_shift: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> lk_gidx == {$past(lk_gidx[GH_W-2:0]), $past(up_taken)});

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(lk_gidx));

  a_r9_agree_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_gpred == lk_lpred) |-> (lk_taken == lk_gpred));

  a_r7_chooser_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && ((up_gpred == up_taken) == (up_lpred == up_taken)))
    |=> choose_tbl[$past(up_gidx)] == $past(choose_tbl[up_gidx]));

  a_r8_chooser_toward_local: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && (up_lpred == up_taken) && (up_gpred != up_taken))
    |=> choose_tbl[$past(up_gidx)] >= $past(choose_tbl[up_gidx]));

  a_r8_chooser_toward_global: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && (up_gpred == up_taken) && (up_lpred != up_taken))
    |=> choose_tbl[$past(up_gidx)] <= $past(choose_tbl[up_gidx]));
endmodule

bind tourney_bp tourney_bp_chk #(.GH_W(GH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_taken   (lk_taken),
  .lk_gpred   (lk_gpred),
  .lk_lpred   (lk_lpred),
  .lk_gidx    (lk_gidx),
  .up_valid   (up_valid),
  .up_taken   (up_taken),
  .up_gidx    (up_gidx),
  .up_gpred   (up_gpred),
  .up_lpred   (up_lpred),
  .choose_tbl (choose_tbl)
);

// File: tb/tb_tourney_bp.sv
`timescale 1ns/1ps
module tb_tourney_bp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_taken, lk_gpred, lk_lpred;
  logic [11:0] lk_gidx;
  logic [9:0]  lk_lidx, lk_lhist;
  logic        up_valid = 1'b0, up_taken = 1'b0, up_gpred = 1'b0, up_lpred = 1'b0;
  logic [11:0] up_gidx = '0;
  logic [9:0]  up_lidx = '0, up_lhist = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [11:0] SG = 12'hFFF;
  localparam logic [9:0]  SL = 10'h3FF;
  localparam logic [9:0]  SH = 10'h3FF;

  always #2.5 clk = ~clk;

  tourney_bp dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
    .lk_taken(lk_taken), .lk_gpred(lk_gpred), .lk_lpred(lk_lpred),
    .lk_gidx(lk_gidx), .lk_lidx(lk_lidx), .lk_lhist(lk_lhist),
    .up_valid(up_valid), .up_taken(up_taken), .up_gidx(up_gidx),
    .up_lidx(up_lidx), .up_lhist(up_lhist), .up_gpred(up_gpred), .up_lpred(up_lpred)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic upd(input logic [11:0] g, input logic [9:0] li, input logic [9:0] lh,
                     input logic gp, input logic lp, input logic t);
    @(negedge clk);
    up_gidx = g; up_lidx = li; up_lhist = lh; up_gpred = gp; up_lpred = lp; up_taken = t;
    up_valid = 1'b1;
    @(negedge clk);
    up_valid = 1'b0;
    #1;
  endtask

  task automatic set_ghr(input logic [11:0] pat);
    for (int i = 11; i >= 0; i--) upd(SG, SL, SH, 1'b0, 1'b0, pat[i]);
  endtask

  task automatic set_lhist(input logic [9:0] li, input logic [9:0] pat);
    for (int i = 9; i >= 0; i--) upd(SG, li, SH, 1'b0, 1'b0, pat[i]);
  endtask

  task automatic gtrain(input logic [11:0] g, input int n, input logic t);
    for (int i = 0; i < n; i++) upd(g, SL, SH, t, t, t);
  endtask

  task automatic ltrain(input logic [9:0] lh, input int n, input logic t);
    for (int i = 0; i < n; i++) upd(SG, SL, lh, t, t, t);
  endtask

  task automatic t_reset;
    lk_pc = 32'h0000_0014;
    #1;
    check("R1 history zero", lk_gidx, 0);
    check("R1 record zero", lk_lhist, 0);
    check("R1 global not taken", lk_gpred, 0);
    check("R1 local not taken", lk_lpred, 0);
    check("R1 output", lk_taken, 0);
  endtask

  task automatic t_ghr;
    set_ghr(12'hABC);
    check("R2 history steer", lk_gidx, 12'hABC);
    upd(SG, SL, SH, 1'b1, 1'b1, 1'b1);
    check("R2 shift in taken", lk_gidx, 12'h579);
  endtask

  task automatic t_idle;
    @(negedge clk);
    up_valid = 1'b0; up_taken = 1'b1; up_gidx = 12'h579; up_gpred = 1'b1; up_lpred = 1'b1;
    @(negedge clk);
    #1;
    check("R10 history unchanged", lk_gidx, 12'h579);
    check("R10 counter unchanged", lk_gpred, 0);
  endtask

  task automatic t_global;
    logic [11:0] g;
    g = 12'h5A5;
    set_ghr(g);
    check("R3 initial weak not taken", lk_gpred, 0);
    gtrain(g, 1, 1'b1);
    set_ghr(g);
    lk_pc = 32'h0000_0000; #1;
    check("R3 one taken", lk_gpred, 1);
    check("R9 follows global", lk_taken, 1);
    lk_pc = 32'h0000_0123; #1;
    check("R3 index ignores pc", lk_gpred, 1);
    gtrain(g, 3, 1'b1);
    gtrain(g, 2, 1'b0);
    set_ghr(g);
    check("R3 saturate high then down", lk_gpred, 0);
    gtrain(g, 5, 1'b0);
    gtrain(g, 1, 1'b1);
    set_ghr(g);
    check("R3 saturate low", lk_gpred, 0);
    gtrain(g, 1, 1'b1);
    set_ghr(g);
    check("R3 threshold two", lk_gpred, 1);
  endtask

  task automatic t_localhist;
    upd(SG, 10'h084, SH, 1'b0, 1'b0, 1'b1);
    upd(SG, 10'h084, SH, 1'b0, 1'b0, 1'b0);
    upd(SG, 10'h084, SH, 1'b0, 1'b0, 1'b1);
    upd(SG, 10'h084, SH, 1'b0, 1'b0, 1'b1);
    lk_pc = 32'h0000_0C84; #1;
    check("R4 index", lk_lidx, 10'h084);
    check("R4 record", lk_lhist, 10'h00B);
    lk_pc = 32'h0000_0884; #1;
    check("R4 alias", lk_lhist, 10'h00B);
    lk_pc = 32'h0000_0C88; #1;
    check("R4 other entry", lk_lhist, 0);
    for (int i = 0; i < 8; i++) upd(SG, 10'h084, SH, 1'b0, 1'b0, 1'b0);
    lk_pc = 32'h0000_0C84; #1;
    check("R4 ten bit truncate", lk_lhist, 10'h300);
  endtask

  task automatic t_localctr;
    logic [9:0] l;
    l = 10'h155;
    set_lhist(10'h2E0, l);
    lk_pc = 32'h0000_02E0; #1;
    check("R5 record steer", lk_lhist, l);
    check("R5 initial", lk_lpred, 0);
    ltrain(l, 1, 1'b1); #1;
    check("R5 threshold four", lk_lpred, 1);
    ltrain(l, 4, 1'b1);
    ltrain(l, 3, 1'b0); #1;
    check("R5 saturate high", lk_lpred, 1);
    ltrain(l, 1, 1'b0); #1;
    check("R5 below four", lk_lpred, 0);
    ltrain(l, 6, 1'b0);
    ltrain(l, 3, 1'b1); #1;
    check("R5 saturate low", lk_lpred, 0);
    ltrain(l, 1, 1'b1); #1;
    check("R5 back to four", lk_lpred, 1);
  endtask

  task automatic ctrain(input logic gp, input logic lp, input int n);
    for (int i = 0; i < n; i++) upd(12'h0F0, SL, SH, gp, lp, 1'b0);
  endtask

  task automatic clook(input string req, input int exp);
    set_ghr(12'h0F0);
    lk_pc = 32'h0000_02E0; #1;
    check(req, lk_taken, exp);
  endtask

  task automatic t_chooser;
    set_ghr(12'h0F0);
    lk_pc = 32'h0000_02E0; #1;
    check("R6 global answer", lk_gpred, 0);
    check("R6 local answer", lk_lpred, 1);
    check("R6 reset favours global", lk_taken, 0);
    ctrain(1'b1, 1'b1, 1);
    clook("R7 both wrong hold", 0);
    ctrain(1'b1, 1'b0, 1);
    clook("R8 local right step up", 1);
    ctrain(1'b0, 1'b0, 1);
    clook("R7 both right hold", 1);
    ctrain(1'b1, 1'b0, 2);
    ctrain(1'b0, 1'b1, 1);
    clook("R8 ceiling three", 1);
    ctrain(1'b0, 1'b1, 1);
    clook("R9 back to global", 0);
    ctrain(1'b0, 1'b1, 2);
    ctrain(1'b1, 1'b0, 1);
    clook("R8 floor zero", 0);
    ctrain(1'b1, 1'b0, 1);
    clook("R8 step to local", 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ghr;
    t_idle;
    t_global;
    t_localhist;
    t_localctr;
    t_chooser;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule